// File: doc/BRIEF.md
# Stepper Driver Fault Diagnosis Logic

This block watches the digital fault indicators of a two-bridge stepper motor driver and decides, each clock, which bridges may conduct and what the two active-low fault flags report. Per-phase comparators flag a shorted bridge and a phase current that stays under 35 % of full scale. Supply comparators flag overvoltage, undervoltage and overtemperature. The analog thresholds themselves are not part of this block.

A bridge short is trusted only after the bridge's blanking window has ended and a further programmable delay has passed. A shorted bridge is switched off until the next step command. The next step command then re-enables it so the check can run again. Low-current flags start out set. They change only on a step command issued while the indexer sits at its home position. Supply faults take priority. Overvoltage forces a safe mode. Undervoltage disables the outputs and sends the indexer home. Overtemperature disables the outputs.

Top module: `motor_fault_diag`

## Requirements
- R1: After reset, `phase_off`, `safe_mode`, `out_dis` and `home_req` are all 0, `ff1_n` is 1 and `ff2_n` is 0, because both low-current flags start set.
- R2: Let edge E0 be the first rising clock edge at which `blank_done[p]` is sampled high after being low. `short_ind[p]` is sampled once, at edge E0+`dly_cycles`+1, and at no other edge.
- R3: A short sampled high sets `phase_off[p]` from that edge on. The flag stays set until a rising edge of `step_in` (low at one edge, high at the next), which clears it. Other phases are unaffected.
- R4: After a step clears a phase, a new rise of `blank_done[p]` runs a fresh sample. A window that was already open when the step arrived does not sample again.
- R5: If `blank_done[p]` is sampled low before edge E0+`dly_cycles`+1, the pending sample is abandoned.
- R6: At a step rising edge with `at_home` high, each phase's low-current flag takes the value of `low_ind[p]`. At a step rising edge with `at_home` low, the flags keep their value.
- R7: Low-current flags never set `phase_off` or `out_dis`.
- R8: `ov_ind` sampled high at an edge sets `safe_mode` from that edge until the edge at which it is sampled low.
- R9: `uv_ind` sampled high sets `out_dis` and `home_req` after that edge. It also clears every short flag and sets every low-current flag.
- R10: `ot_ind` sampled high sets `out_dis` after that edge.
- R11: Fault flag encoding, in priority order, is as follows. Any registered supply or thermal fault drives both flags low. Otherwise, any short drives `ff1_n` low with `ff2_n` high. Otherwise, any low-current flag drives `ff2_n` low with `ff1_n` high. Otherwise, both flags are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_in | input | 1 | Step command; its rising edge is the event |
| at_home | input | 1 | Indexer is at the home microstep |
| dly_cycles | input | DLY_W | Extra cycles after blanking before a short is sampled |
| blank_done | input | NP | Per phase: blanking window over, bridge conducting |
| short_ind | input | NP | Per phase short comparator |
| low_ind | input | NP | Per phase current below 35 % of full scale |
| ov_ind | input | 1 | Supply overvoltage |
| uv_ind | input | 1 | Logic or regulator undervoltage |
| ot_ind | input | 1 | Overtemperature |
| phase_off | output | NP | Per phase bridge disable from a short |
| safe_mode | output | 1 | Low sides on, high sides off |
| out_dis | output | 1 | All bridges disabled |
| home_req | output | 1 | Indexer reset to home |
| ff1_n | output | 1 | Fault flag 1, active low |
| ff2_n | output | 1 | Fault flag 2, active low |

## Verification
The assertions assume the fault comparators are synchronous to `clk`. They also assume `dly_cycles` changes only while no blanking window is pending, since a change mid-window would move the sample edge. The stimulus meets both conditions. Every input is driven on the falling clock edge, and `dly_cycles` is written only while every `blank_done` is low. The short-clearing check also expects `step_in` to be low for at least one cycle between commands, and the bench shapes every step as a one-cycle high pulse.

// File: rtl/fd_pkg.sv
package fd_pkg;
  // Fault flag pair {ff1_n, ff2_n}; supply fault outranks short, short outranks low-current.
  function automatic logic [1:0] flag_encode(input logic sup_flt,
                                             input logic any_short,
                                             input logic any_low);
    logic [1:0] f;
    if (sup_flt)        f = 2'b00;
    else if (any_short) f = 2'b01;
    else if (any_low)   f = 2'b10;
    else                f = 2'b11;
    return f;
  endfunction
endpackage

// File: rtl/fd_short_sampler.sv
module fd_short_sampler #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             blank,
  input  logic             short_i,
  input  logic [DLY_W-1:0] dly,
  output logic             shorted
);
  logic             blank_q;
  logic             armed;
  logic [DLY_W-1:0] cnt;
  logic             blank_rise;
  logic             sample_now;

  assign blank_rise = blank && !blank_q;
  assign sample_now = armed && blank && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= 1'b0;
      armed   <= 1'b0;
      cnt     <= '0;
    end else begin
      blank_q <= blank;
      if (!blank) begin
        armed <= 1'b0;
      end else if (blank_rise) begin
        armed <= 1'b1;
        cnt   <= dly;
      end else if (sample_now) begin
        armed <= 1'b0;
      end else if (armed) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    shorted <= 1'b0;
    else if (clr)                  shorted <= 1'b0;
    else if (sample_now && short_i) shorted <= 1'b1;
  end
endmodule

// File: rtl/fd_lowload.sv
module fd_lowload #(
  parameter int NP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_all,
  input  logic          eval,
  input  logic [NP-1:0] low_i,
  output logic [NP-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags <= '1;
    else if (set_all) flags <= '1;
    else if (eval)    flags <= low_i;
  end
endmodule

// File: rtl/motor_fault_diag.sv
module motor_fault_diag
  import fd_pkg::*;
#(
  parameter int NP    = 2,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_in,
  input  logic             at_home,
  input  logic [DLY_W-1:0] dly_cycles,
  input  logic [NP-1:0]    blank_done,
  input  logic [NP-1:0]    short_ind,
  input  logic [NP-1:0]    low_ind,
  input  logic             ov_ind,
  input  logic             uv_ind,
  input  logic             ot_ind,
  output logic [NP-1:0]    phase_off,
  output logic             safe_mode,
  output logic             out_dis,
  output logic             home_req,
  output logic             ff1_n,
  output logic             ff2_n
);
  logic          step_q;
  logic          step_rise;
  logic          short_clr;
  logic          home_eval;
  logic          ov_q, uv_q, ot_q;
  logic [NP-1:0] ll_flags;
  logic [1:0]    flags;

  assign step_rise = step_in && !step_q;
  assign short_clr = step_rise || uv_ind;
  assign home_eval = step_rise && at_home;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= 1'b0;
      ov_q   <= 1'b0;
      uv_q   <= 1'b0;
      ot_q   <= 1'b0;
    end else begin
      step_q <= step_in;
      ov_q   <= ov_ind;
      uv_q   <= uv_ind;
      ot_q   <= ot_ind;
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_phase
    fd_short_sampler #(.DLY_W(DLY_W)) u_smp (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (short_clr),
      .blank   (blank_done[p]),
      .short_i (short_ind[p]),
      .dly     (dly_cycles),
      .shorted (phase_off[p])
    );
  end

  fd_lowload #(.NP(NP)) u_ll (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_all (uv_ind),
    .eval    (home_eval),
    .low_i   (low_ind),
    .flags   (ll_flags)
  );

  assign flags     = flag_encode(ov_q || uv_q || ot_q, |phase_off, |ll_flags);
  assign ff1_n     = flags[1];
  assign ff2_n     = flags[0];
  assign safe_mode = ov_q;
  assign out_dis   = uv_q || ot_q;
  assign home_req  = uv_q;
endmodule

// File: rtl/fd_chk.sv
module fd_chk #(
  parameter int NP = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step_rise,
  input logic [NP-1:0] blank_done,
  input logic          ov_ind,
  input logic          uv_ind,
  input logic          ot_ind,
  input logic [NP-1:0] phase_off,
  input logic          safe_mode,
  input logic          out_dis,
  input logic          home_req,
  input logic          ff1_n,
  input logic          ff2_n
);
  // R2
  short_after_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_off[0]) |-> $past(blank_done[0]));

  // R3
  step_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_rise |=> (phase_off == '0));

  // R8
  ov_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov_ind |=> (safe_mode && !ff1_n && !ff2_n));

  // R9
  uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_ind |=> (out_dis && home_req && (phase_off == '0)));

  // R10
  ot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ot_ind |=> (out_dis && !ff1_n && !ff2_n));

  // R11
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ff1_n && ff2_n) |-> (phase_off == '0 && !safe_mode && !out_dis));
endmodule

bind motor_fault_diag fd_chk #(.NP(NP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_rise  (step_rise),
  .blank_done (blank_done),
  .ov_ind     (ov_ind),
  .uv_ind     (uv_ind),
  .ot_ind     (ot_ind),
  .phase_off  (phase_off),
  .safe_mode  (safe_mode),
  .out_dis    (out_dis),
  .home_req   (home_req),
  .ff1_n      (ff1_n),
  .ff2_n      (ff2_n)
);

// File: tb/motor_fault_diag_tb.sv
module motor_fault_diag_tb;
  localparam int NP = 2;
  localparam int DW = 8;

  typedef struct {
    string    req;
    logic [1:0] po;
    logic     sm, od, hr, f1, f2;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_in = 1'b0, at_home = 1'b0;
  logic [DW-1:0] dly_cycles = '0;
  logic [NP-1:0] blank_done = '0, short_ind = '0, low_ind = '0;
  logic ov_ind = 1'b0, uv_ind = 1'b0, ot_ind = 1'b0;
  logic [NP-1:0] phase_off;
  logic safe_mode, out_dis, home_req, ff1_n, ff2_n;

  int total = 0, bad = 0;
  bit done = 0;
  exp_t sb[$];
  event chk_ev;

  always #10 clk = ~clk;

  motor_fault_diag #(.NP(NP), .DLY_W(DW)) u_dut (.*);

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(string req, logic [1:0] po, logic sm, logic od,
                            logic hr, logic f1, logic f2);
    exp_t e;
    e.req = req; e.po = po; e.sm = sm; e.od = od; e.hr = hr; e.f1 = f1; e.f2 = f2;
    sb.push_back(e);
    ->chk_ev;
    #2;
  endtask

  // expected flag pair, restated from the priority list
  function automatic logic [1:0] flag_pair(bit supply, bit shrt, bit low);
    if (supply) return 2'b00;
    if (shrt)   return 2'b01;
    if (low)    return 2'b10;
    return 2'b11;
  endfunction

  task automatic step_pulse(logic home);
    at_home = home;
    step_in = 1'b1;
    tick();
    step_in = 1'b0;
    tick();
  endtask

  initial begin : monitor
    forever begin
      @(chk_ev);
      #1;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (phase_off !== e.po || safe_mode !== e.sm || out_dis !== e.od ||
            home_req !== e.hr || ff1_n !== e.f1 || ff2_n !== e.f2) begin
          bad++;
          $display("FAIL %s: got po=%b sm=%b od=%b hr=%b ff=%b%b exp po=%b sm=%b od=%b hr=%b ff=%b%b",
                   e.req, phase_off, safe_mode, out_dis, home_req, ff1_n, ff2_n,
                   e.po, e.sm, e.od, e.hr, e.f1, e.f2);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    logic [1:0] f;
    tick(2);
    rst_n = 1'b1;
    tick();
    f = flag_pair(0, 0, 1);
    expect_out("R1", 2'b00, 0, 0, 0, f[1], f[0]);

    // R6: home step with both phases passing clears low-current flags
    low_ind = 2'b00;
    step_pulse(1'b1);
    f = flag_pair(0, 0, 0);
    expect_out("R6", 2'b00, 0, 0, 0, f[1], f[0]);

    // R2: dly=3, sample at E0+4
    dly_cycles = 8'd3;
    short_ind = 2'b01;
    blank_done = 2'b01;
    tick(4);
    expect_out("R2", 2'b00, 0, 0, 0, 1, 1);
    tick();
    f = flag_pair(0, 1, 0);
    expect_out("R2", 2'b01, 0, 0, 0, f[1], f[0]);
    tick(3);
    expect_out("R3", 2'b01, 0, 0, 0, f[1], f[0]);

    // R3: step clears although short persists; R4: open window no resample
    step_pulse(1'b0);
    expect_out("R3", 2'b00, 0, 0, 0, 1, 1);
    tick(8);
    expect_out("R4", 2'b00, 0, 0, 0, 1, 1);

    // R4: fresh window resamples; short present again
    blank_done = 2'b00;
    tick();
    blank_done = 2'b01;
    tick(5);
    expect_out("R4", 2'b01, 0, 0, 0, 0, 1);
    step_pulse(1'b0);
    blank_done = 2'b00;
    short_ind = 2'b00;
    tick();

    // R2: short seen only before the sample edge is ignored
    short_ind = 2'b01;
    blank_done = 2'b01;
    tick(2);
    short_ind = 2'b00;
    tick(6);
    expect_out("R2", 2'b00, 0, 0, 0, 1, 1);
    blank_done = 2'b00;
    tick();

    // R5: phase 1 window abandoned early
    short_ind = 2'b10;
    blank_done = 2'b10;
    tick(2);
    blank_done = 2'b00;
    tick(6);
    expect_out("R5", 2'b00, 0, 0, 0, 1, 1);
    blank_done = 2'b10;
    tick(5);
    expect_out("R3", 2'b10, 0, 0, 0, 0, 1);
    step_pulse(1'b0);
    blank_done = 2'b00;
    short_ind = 2'b00;
    tick();

    // R2: zero delay samples at the edge after the rise edge
    dly_cycles = 8'd0;
    short_ind = 2'b01;
    blank_done = 2'b01;
    tick();
    expect_out("R2", 2'b00, 0, 0, 0, 1, 1);
    tick();
    expect_out("R2", 2'b01, 0, 0, 0, 0, 1);
    step_pulse(1'b0);
    blank_done = 2'b00;
    short_ind = 2'b00;
    tick();

    // R6/R7: home check with phase 1 low
    low_ind = 2'b10;
    step_pulse(1'b1);
    f = flag_pair(0, 0, 1);
    expect_out("R7", 2'b00, 0, 0, 0, f[1], f[0]);
    low_ind = 2'b00;
    step_pulse(1'b0);
    expect_out("R6", 2'b00, 0, 0, 0, f[1], f[0]);

    // R11: short outranks low-current
    short_ind = 2'b10;
    blank_done = 2'b10;
    tick(2);
    f = flag_pair(0, 1, 1);
    expect_out("R11", 2'b10, 0, 0, 0, f[1], f[0]);

    // R8: overvoltage
    ov_ind = 1'b1;
    tick();
    expect_out("R8", 2'b10, 1, 0, 0, 0, 0);
    ov_ind = 1'b0;
    tick();
    expect_out("R8", 2'b10, 0, 0, 0, 0, 1);

    // R10: overtemperature
    ot_ind = 1'b1;
    tick();
    expect_out("R10", 2'b10, 0, 1, 0, 0, 0);
    ot_ind = 1'b0;
    tick();

    // R6 clear low flags, then R9 undervoltage
    blank_done = 2'b00;
    short_ind = 2'b00;
    step_pulse(1'b1);
    expect_out("R6", 2'b00, 0, 0, 0, 1, 1);
    short_ind = 2'b01;
    blank_done = 2'b01;
    tick(2);
    expect_out("R3", 2'b01, 0, 0, 0, 0, 1);
    uv_ind = 1'b1;
    tick();
    expect_out("R9", 2'b00, 0, 1, 1, 0, 0);
    uv_ind = 1'b0;
    tick();
    f = flag_pair(0, 0, 1);
    expect_out("R9", 2'b00, 0, 0, 0, f[1], f[0]);

    done = 1;
    tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule